// File: doc/BRIEF.md
# Buffered Flash Page-Program Unit

This block is the write path of a serial NOR flash controller. Software loads a program opcode, up to four address bytes and either one data byte or a full page, then sets a start bit. The unit then runs the whole program sequence on a single-lane SPI bus. By default it sends a write-enable command in its own chip-select frame, then the program frame (opcode, address, data), and then it polls the flash status register until the write-in-progress flag drops. Each of the two extra steps can be turned off by a configuration bit. The start bit clears itself when the sequence is over.

A page mode is selected through an enable bit with a handshake. The new value only shows in the readback once the unit has switched over, so software polls that bit after changing it. In page mode, 32-bit writes to a data port fill a page buffer (default 128 bytes). The buffer is laid out so an FPGA block RAM can hold it. Outside page mode, a single byte register is programmed alone.

Top module: `flash_pp_unit`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, and reads of offsets 0x00 and 0x64 return 0.
- R2: A write to offset 0x64 requests page mode from bit 0. The readback of bit 0 keeps the old value and takes the new one EN_LAT cycles later. The switch is held off while a program runs.
- R3: In page mode a program sends exactly PAGE_BYTES data bytes, taken from the words written to offset 0x98 in order. Byte k of a word is held in bits 8k+7:8k and is sent before byte k+1.
- R4: Outside page mode a program sends exactly one data byte, the low byte last written to offset 0x1C.
- R5: Address bytes are sent most significant first. They are the 0x18, 0x14 and 0x10 bytes; when bit 4 of offset 0xCC is set, the 0xC8 byte goes before them.
- R6: The first byte of the program frame is the low byte of offset 0x20.
- R7: Unless bit 7 of offset 0xB4 is set, a one-byte frame holding 0x06 comes before the program frame, with chip select high between the two frames.
- R8: Unless bit 5 of offset 0xB4 is set, the program frame is followed by a frame holding 0x05. That frame then clocks status bytes (sending 0x00) until one is read with bit 0 clear.
- R9: Writing offset 0x00 with bit 4 set while idle starts a program. Bit 4 of offset 0x00 reads 1 for the whole sequence and returns to 0 after the last frame ends.
- R10: While a program runs, all register writes are ignored. Writes to 0x98 are also ignored while page mode is off or a mode change is pending. The page fill position goes back to the first word after every program.
- R11: SPI mode 0: spi_sclk idles low whenever spi_cs_n is high. spi_mosi changes only while spi_sclk is low. Bits are sent most significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The interesting collision is a register write landing while the sequencer is still clocking a program out. This matters most for writes to the page port, the opcode and the start bit, and for a mode change that could switch the data source mid-page. The bench issues such writes after checking that the busy bit reads 1. It then judges the captured SPI frames: opcode, address and page bytes must be unchanged, no second program may appear, and the next page must start again at word 0. Status polling with several busy replies is provoked by a bench flash model that answers a set number of status bytes with bit 0 set.

// File: rtl/flash_pp_pkg.sv
package flash_pp_pkg;
  // register byte offsets
  localparam int OFF_CMD    = 'h000;
  localparam int OFF_AB0    = 'h010;
  localparam int OFF_AB1    = 'h014;
  localparam int OFF_AB2    = 'h018;
  localparam int OFF_BYTE   = 'h01C;
  localparam int OFF_OPC    = 'h020;
  localparam int OFF_MODE   = 'h064;
  localparam int OFF_PAGE   = 'h098;
  localparam int OFF_STEPS  = 'h0B4;
  localparam int OFF_AB3    = 'h0C8;
  localparam int OFF_BUS    = 'h0CC;
  // bit positions
  localparam int GO_BIT     = 4;
  localparam int MODE_BIT   = 0;
  localparam int NOWREN_BIT = 7;
  localparam int NOPOLL_BIT = 5;
  localparam int WIDE_BIT   = 4;
  // flash commands issued by the unit itself
  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_RDSR = 8'h05;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_OPC, S_ADDR, S_DATA, S_PCMD, S_PRD, S_GAP, S_FIN
  } seq_st_e;
endpackage

// File: rtl/flash_pp_shifter.sv
module flash_pp_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int HW = $clog2(HALF + 1);

  logic [HW-1:0] hc;
  logic          ph, active;
  logic [2:0]    bitn;
  logic [7:0]    shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; sclk <= 1'b0; mosi <= 1'b0; done <= 1'b0;
      hc <= '0; ph <= 1'b0; bitn <= '0; shreg <= '0; rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        shreg  <= tx_byte;
        mosi   <= tx_byte[7];
        hc     <= '0;
        ph     <= 1'b0;
        bitn   <= '0;
      end else if (active) begin
        if (hc == HW'(HALF - 1)) begin
          hc <= '0;
          if (!ph) begin
            sclk    <= 1'b1;
            ph      <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sclk <= 1'b0;
            ph   <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitn  <= bitn + 3'd1;
              shreg <= {shreg[6:0], 1'b0};
              mosi  <= shreg[6];
            end
          end
        end else begin
          hc <= hc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_pp_pagebuf.sv
module flash_pp_pagebuf #(
  parameter int WORDS = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_pp_seq.sv
module flash_pp_seq
  import flash_pp_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int CS_GAP     = 2,
  parameter int WAW        = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           skip_wren,
  input  logic           skip_poll,
  input  logic           addr4,
  input  logic           paged,
  input  logic [7:0]     opcode,
  input  logic [31:0]    addr,
  input  logic [7:0]     single_byte,
  input  logic [31:0]    page_word,
  output logic [WAW-1:0] page_idx,
  output logic           sh_start,
  output logic [7:0]     sh_byte,
  input  logic           sh_done,
  input  logic           sh_rx0,
  output logic           cs_n,
  output logic           finish
);
  localparam int CW = WAW + 2;
  localparam int GW = $clog2(CS_GAP + 1);

  seq_st_e       st, gap_st;
  logic [GW-1:0] gap_cnt;
  logic [CW-1:0] cnt;
  logic          inflight, just_done, cs_q, in_byte;

  assign in_byte  = (st == S_WREN) || (st == S_OPC) || (st == S_ADDR) ||
                    (st == S_DATA) || (st == S_PCMD) || (st == S_PRD);
  assign sh_start = in_byte && !inflight && !just_done;
  assign page_idx = cnt[CW-1:2];
  assign cs_n     = cs_q;
  assign finish   = (st == S_FIN);

  always_comb begin
    case (st)
      S_WREN:  sh_byte = CMD_WREN;
      S_OPC:   sh_byte = opcode;
      S_ADDR:  sh_byte = addr[8*cnt[1:0] +: 8];
      S_DATA:  sh_byte = paged ? page_word[8*cnt[1:0] +: 8] : single_byte;
      S_PCMD:  sh_byte = CMD_RDSR;
      default: sh_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; gap_st <= S_FIN; gap_cnt <= '0; cnt <= '0;
      inflight <= 1'b0; just_done <= 1'b0; cs_q <= 1'b1;
    end else begin
      just_done <= sh_done;
      if (sh_start)     inflight <= 1'b1;
      else if (sh_done) inflight <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st   <= skip_wren ? S_OPC : S_WREN;
          cs_q <= 1'b0;
        end
        S_WREN: if (sh_done) begin
          st <= S_GAP; gap_st <= S_OPC; cs_q <= 1'b1;
        end
        S_OPC: if (sh_done) begin
          st  <= S_ADDR;
          cnt <= addr4 ? CW'(3) : CW'(2);
        end
        S_ADDR: if (sh_done) begin
          if (cnt == '0) st <= S_DATA;
          else           cnt <= cnt - 1'b1;
        end
        S_DATA: if (sh_done) begin
          if (!paged || cnt == CW'(PAGE_BYTES - 1)) begin
            st     <= S_GAP;
            gap_st <= skip_poll ? S_FIN : S_PCMD;
            cs_q   <= 1'b1;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PCMD: if (sh_done) st <= S_PRD;
        S_PRD: if (sh_done && !sh_rx0) begin
          st <= S_GAP; gap_st <= S_FIN; cs_q <= 1'b1;
        end
        S_GAP: begin
          if (gap_cnt == GW'(CS_GAP - 1)) begin
            gap_cnt <= '0;
            st      <= gap_st;
            cs_q    <= (gap_st == S_FIN);
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_pp_unit.sv
module flash_pp_unit
  import flash_pp_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 128,
  parameter int EN_LAT     = 8,
  parameter int SCK_HALF   = 2,
  parameter int CS_GAP     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int WORDS = PAGE_BYTES / 4;
  localparam int WAW   = $clog2(WORDS);
  localparam int ECW   = $clog2(EN_LAT + 1);

  logic [7:0]       op_q, byte_q;
  logic [3:0][7:0]  ab_q;
  logic             wide_q, nowren_q, nopoll_q, busy_q;
  logic             en_req_q, en_eff_q;
  logic [ECW-1:0]   en_cnt_q;
  logic [WAW-1:0]   wptr_q, ridx;
  logic [31:0]      rdata_q, page_word;
  logic             wr_ok, go, pw_we, seq_fin;
  logic             sh_start, sh_done;
  logic [7:0]       sh_byte, sh_rx;
  logic             unused_rx;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign wr_ok     = reg_we && !busy_q;
  assign go        = wr_ok && hit(reg_addr, OFF_CMD) && reg_wdata[GO_BIT];
  assign pw_we     = wr_ok && hit(reg_addr, OFF_PAGE) && en_eff_q && (en_cnt_q == '0);
  assign reg_rdata = rdata_q;
  assign unused_rx = ^sh_rx[7:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= '0; byte_q <= '0; ab_q <= '0;
      wide_q <= 1'b0; nowren_q <= 1'b0; nopoll_q <= 1'b0; busy_q <= 1'b0;
      en_req_q <= 1'b0; en_eff_q <= 1'b0; en_cnt_q <= '0; wptr_q <= '0;
    end else begin
      if (go) busy_q <= 1'b1;
      else if (seq_fin) busy_q <= 1'b0;
      if (wr_ok) begin
        if (hit(reg_addr, OFF_OPC))   op_q     <= reg_wdata[7:0];
        if (hit(reg_addr, OFF_BYTE))  byte_q   <= reg_wdata[7:0];
        if (hit(reg_addr, OFF_AB0))   ab_q[0]  <= reg_wdata[7:0];
        if (hit(reg_addr, OFF_AB1))   ab_q[1]  <= reg_wdata[7:0];
        if (hit(reg_addr, OFF_AB2))   ab_q[2]  <= reg_wdata[7:0];
        if (hit(reg_addr, OFF_AB3))   ab_q[3]  <= reg_wdata[7:0];
        if (hit(reg_addr, OFF_BUS))   wide_q   <= reg_wdata[WIDE_BIT];
        if (hit(reg_addr, OFF_STEPS)) begin
          nowren_q <= reg_wdata[NOWREN_BIT];
          nopoll_q <= reg_wdata[NOPOLL_BIT];
        end
      end
      // page-mode handshake: readback follows the request after EN_LAT cycles
      if (wr_ok && hit(reg_addr, OFF_MODE)) begin
        en_req_q <= reg_wdata[MODE_BIT];
        en_cnt_q <= (reg_wdata[MODE_BIT] != en_eff_q) ? ECW'(EN_LAT) : '0;
        if (reg_wdata[MODE_BIT] != en_eff_q) wptr_q <= '0;
      end else if (en_cnt_q != '0 && !busy_q) begin
        en_cnt_q <= en_cnt_q - 1'b1;
        if (en_cnt_q == ECW'(1)) en_eff_q <= en_req_q;
      end
      if (pw_we)        wptr_q <= wptr_q + 1'b1;
      else if (seq_fin) wptr_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_re) begin
      rdata_q <= '0;
      if (hit(reg_addr, OFF_CMD))   rdata_q[GO_BIT]     <= busy_q;
      if (hit(reg_addr, OFF_OPC))   rdata_q[7:0]        <= op_q;
      if (hit(reg_addr, OFF_BYTE))  rdata_q[7:0]        <= byte_q;
      if (hit(reg_addr, OFF_AB0))   rdata_q[7:0]        <= ab_q[0];
      if (hit(reg_addr, OFF_AB1))   rdata_q[7:0]        <= ab_q[1];
      if (hit(reg_addr, OFF_AB2))   rdata_q[7:0]        <= ab_q[2];
      if (hit(reg_addr, OFF_AB3))   rdata_q[7:0]        <= ab_q[3];
      if (hit(reg_addr, OFF_MODE))  rdata_q[MODE_BIT]   <= en_eff_q;
      if (hit(reg_addr, OFF_BUS))   rdata_q[WIDE_BIT]   <= wide_q;
      if (hit(reg_addr, OFF_STEPS)) begin
        rdata_q[NOWREN_BIT] <= nowren_q;
        rdata_q[NOPOLL_BIT] <= nopoll_q;
      end
    end
  end

  flash_pp_pagebuf #(.WORDS(WORDS), .AW(WAW)) u_buf (
    .clk(clk), .we(pw_we), .waddr(wptr_q), .wdata(reg_wdata),
    .raddr(ridx), .rdata(page_word)
  );

  flash_pp_seq #(.PAGE_BYTES(PAGE_BYTES), .CS_GAP(CS_GAP), .WAW(WAW)) u_seq (
    .clk(clk), .rst(rst), .go(go), .skip_wren(nowren_q), .skip_poll(nopoll_q),
    .addr4(wide_q), .paged(en_eff_q), .opcode(op_q), .addr(ab_q),
    .single_byte(byte_q), .page_word(page_word), .page_idx(ridx),
    .sh_start(sh_start), .sh_byte(sh_byte), .sh_done(sh_done),
    .sh_rx0(sh_rx[0]), .cs_n(spi_cs_n), .finish(seq_fin)
  );

  flash_pp_shifter #(.HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx_byte(sh_byte),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .done(sh_done), .rx_byte(sh_rx)
  );
endmodule

// File: rtl/flash_pp_unit_chk.sv
module flash_pp_unit_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic              busy,
  input logic              en_eff,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              go_bit
);
  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R11
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R9
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == '0 && go_bit && !busy) |=> busy);

  // R9
  cs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  // R2
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(en_eff));
endmodule

bind flash_pp_unit flash_pp_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
  .busy(busy_q), .en_eff(en_eff_q), .reg_we(reg_we), .reg_addr(reg_addr),
  .go_bit(reg_wdata[4])
);

// File: tb/flash_pp_unit_tb.sv
`timescale 1ns/1ps
module flash_pp_unit_tb;
  localparam int PAGE_BYTES = 128;
  localparam int WORDS      = PAGE_BYTES / 4;
  localparam int EN_LAT     = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  flash_pp_unit #(.ADDR_W(12), .PAGE_BYTES(PAGE_BYTES), .EN_LAT(EN_LAT),
                  .SCK_HALF(2), .CS_GAP(2)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // ---------------- flash model: frame capture and status replies
  logic [7:0] lb [0:511];
  int         fl [0:15];
  int         nb = 0, nf = 0, cur_len = 0, bitc = 0, stat_left = 0, stat_cfg = 0;
  logic [7:0] sh = '0, cur_stat = '0;
  bit         is_stat = 0;

  always @(negedge spi_cs_n) begin
    bitc = 0; is_stat = 0; stat_left = stat_cfg; spi_miso = 1'b0;
  end
  always @(posedge spi_cs_n) begin
    if (cur_len > 0) begin
      if (nf < 16) fl[nf] = cur_len;
      nf++; cur_len = 0;
    end
  end
  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      sh = {sh[6:0], spi_mosi};
      bitc++;
      if (bitc % 8 == 0) begin
        if (nb < 512) lb[nb] = sh;
        if (bitc == 8) is_stat = (sh == 8'h05);
        nb++; cur_len++;
      end
    end
  end
  always @(negedge spi_sclk) begin
    if (!spi_cs_n && is_stat && bitc >= 8) begin
      if (bitc % 8 == 0) begin
        cur_stat = (stat_left > 0) ? 8'h03 : 8'h00;
        if (stat_left > 0) stat_left--;
      end
      spi_miso = cur_stat[7 - (bitc % 8)];
    end
  end

  // ---------------- bench helpers
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin rd(12'h000, v); n++; end while (v[4] && n < 20000);
  endtask

  task automatic set_mode(input bit m);
    wr(12'h064, {31'd0, m});
    repeat (EN_LAT + 4) @(negedge clk);
  endtask

  logic [31:0] page [0:WORDS-1];
  logic [7:0]  eb [0:511];
  int          efl [0:15];
  string       etag [0:15];

  // expected stream from requirements: R7 frame, R3..R6 frame, R8 frame
  task automatic run_prog(input bit pg, input bit a4, input bit sw, input bit sp,
                          input int polls, input logic [31:0] ad,
                          input logic [7:0] opc, input logic [7:0] sb);
    logic [31:0] v;
    int e, enf, base, mism;
    wr(12'h020, {24'd0, opc});
    wr(12'h010, {24'd0, ad[7:0]});
    wr(12'h014, {24'd0, ad[15:8]});
    wr(12'h018, {24'd0, ad[23:16]});
    wr(12'h0C8, {24'd0, ad[31:24]});
    wr(12'h0CC, {27'd0, a4, 4'd0});
    wr(12'h0B4, {24'd0, sw, 1'b0, sp, 5'd0});
    wr(12'h01C, {24'd0, sb});
    if (pg) for (int i = 0; i < WORDS; i++) begin
      page[i] = $urandom;
      wr(12'h098, page[i]);
    end
    nb = 0; nf = 0; cur_len = 0; stat_cfg = polls;
    wr(12'h000, 32'h10);
    repeat (30) @(negedge clk);
    rd(12'h000, v);
    chk("R9 busy reads 1 during sequence", {31'd0, v[4]}, 32'd1);
    // writes colliding with the running program (R10)
    wr(12'h098, 32'hDEAD_BEEF);
    wr(12'h020, {24'd0, ~opc});
    wr(12'h000, 32'h10);
    wait_idle();
    repeat (100) @(negedge clk);
    rd(12'h000, v);
    chk("R9 start bit self-cleared", {31'd0, v[4]}, 32'd0);
    rd(12'h020, v);
    chk("R10 opcode write during run ignored", v, {24'd0, opc});

    e = 0; enf = 0;
    if (!sw) begin
      eb[e] = 8'h06; e++; efl[enf] = 1; etag[enf] = "R7 write-enable frame"; enf++;
    end
    base = e;
    eb[e] = opc; e++;
    if (a4) begin eb[e] = ad[31:24]; e++; end
    eb[e] = ad[23:16]; e++;
    eb[e] = ad[15:8];  e++;
    eb[e] = ad[7:0];   e++;
    if (pg) begin
      for (int j = 0; j < PAGE_BYTES; j++) begin
        eb[e] = page[j / 4][8 * (j % 4) +: 8]; e++;
      end
    end else begin
      eb[e] = sb; e++;
    end
    efl[enf] = e - base; etag[enf] = "R3/R4/R5/R6 program frame"; enf++;
    if (!sp) begin
      base = e;
      eb[e] = 8'h05; e++;
      for (int j = 0; j <= polls; j++) begin eb[e] = 8'h00; e++; end
      efl[enf] = e - base; etag[enf] = "R8 status-poll frame"; enf++;
    end

    chk("R7/R8 frame count", nf, enf);
    base = 0;
    for (int f = 0; f < enf && f < nf; f++) begin
      mism = 0;
      for (int j = 0; j < efl[f]; j++)
        if (lb[base + j] !== eb[base + j]) mism++;
      // packed as length<<16 | mismatching bytes
      chk(etag[f], (fl[f] << 16) | mism, efl[f] << 16);
      base += efl[f];
    end
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  // ---------------- main sequence
  initial begin
    logic [31:0] v;
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cs_n idle high", {31'd0, spi_cs_n}, 32'd1);
    chk("R1/R11 sclk idle low", {31'd0, spi_sclk}, 32'd0);
    rd(12'h000, v); chk("R1 command reads 0", v, 32'd0);
    rd(12'h064, v); chk("R1 page mode reads 0", v, 32'd0);

    // R4 single byte, full sequence with two busy status replies
    run_prog(0, 0, 0, 0, 2, 32'h00A1_B2C3, 8'h02, 8'h5A);

    // R10 page-port writes while page mode is off must be dropped
    for (int i = 0; i < 3; i++) wr(12'h098, 32'hBAD0_0000 | i);

    // R2 handshake: old value first, new value after the latency
    wr(12'h064, 32'd1);
    rd(12'h064, v); chk("R2 page mode not yet switched", {31'd0, v[0]}, 32'd0);
    repeat (EN_LAT + 4) @(negedge clk);
    rd(12'h064, v); chk("R2 page mode switched on", {31'd0, v[0]}, 32'd1);

    // R3 full page, 3-byte address, write-enable and polling
    run_prog(1, 0, 0, 0, 3, $urandom, 8'h02, 8'h00);
    // R5 4-byte address, both extra steps skipped; fill restarts at word 0 (R10)
    run_prog(1, 1, 1, 1, 0, $urandom, 8'h12, 8'h00);

    // random mix
    for (int k = 0; k < 4; k++) begin
      bit pg;
      pg = $urandom_range(0, 1);
      set_mode(pg);
      run_prog(pg, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 4), $urandom, 8'($urandom), 8'($urandom));
    end

    // R2 back to single-byte mode
    set_mode(1);
    wr(12'h064, 32'd0);
    rd(12'h064, v); chk("R2 page mode still on", {31'd0, v[0]}, 32'd1);
    repeat (EN_LAT + 4) @(negedge clk);
    rd(12'h064, v); chk("R2 page mode switched off", {31'd0, v[0]}, 32'd0);
    run_prog(0, 1, 1, 0, 1, 32'hFEDC_BA98, 8'h32, 8'hC3);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule